// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block maps a 32-bit linear address to a physical address. The mapping lives in two levels of tables in memory, each made of 32-bit entries. The ten most significant address bits select a directory entry, and that entry points to a page table. The next ten bits select an entry in that page table, and that entry names a 4 KB frame. The twelve low bits pass through unchanged as the byte offset within the frame. A request carries the address, a user/supervisor flag and a write flag. The answer is either a physical address or a page fault.

A small fully associative translation cache holds recent results, so a repeated page is answered one cycle after it is accepted, with no table access. On a miss the walker reads the directory entry and then the page table entry through a simple word memory port. The memory returns read data on the cycle after a read strobe and takes a write in the cycle its write strobe is high. The walker checks that both entries are present and checks the requested access against the permission bits of both levels. It sets the accessed and dirty flags in memory before it answers. The cache fills in round-robin order, and a flush input empties it in one cycle.

Top module: `pageWalker`

## Requirements
- R1: Physical address = entry bits 31..12 (frame) concatenated with linear address bits 11..0.
- R2: A miss reads the directory entry at {dirFrame, addr[31:22], 2'b00} and then the table entry at {directory entry[31:12], addr[21:12], 2'b00}. The memory port never reads and writes in the same cycle.
- R3: If the present bit (entry bit 0) is clear at either level, the walk ends with rspFault=1 and rspPhys=0, and nothing is written to memory.
- R4: Permission uses the user bit (entry bit 2) and the write bit (entry bit 1), each taken as the AND of its value at both levels. A supervisor access (reqUser=0) is always allowed. A user access needs user=1, and a user write also needs write=1. A denied access faults and writes nothing, whether it was a miss or a cache hit.
- R5: On a successful walk, the accessed bit (bit 5) is written as 1 into each entry whose accessed bit was clear. An entry whose accessed bit is already set and that needs no dirty update is not written.
- R6: A successful write walk sets the dirty bit (bit 6) in the page table entry.
- R7: A cache hit that is allowed answers with rspValid in the cycle after acceptance and makes no memory access. rspValid is only ever high while reqReady is high.
- R8: An allowed write that hits a cached entry whose dirty flag is clear does a full walk and sets the dirty bit. The next write to that page is a hit.
- R9: The cache holds 32 entries, replaced round-robin. After 33 distinct pages are filled, the first page misses and the second page still hits.
- R10: A fault never puts an entry in the cache. A flush pulse invalidates every entry, so the next request to any page walks the tables again.
- R11: After reset: reqReady=1, rspValid=0, and no memory strobe is high. While reqReady is high, the memory strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cache entries |
| dirFrame | input | 20 | Frame number of the directory table |
| reqValid | input | 1 | Translation request strobe |
| reqReady | output | 1 | Walker idle and accepting a request |
| reqAddr | input | 32 | Linear address |
| reqUser | input | 1 | 1 = user access, 0 = supervisor |
| reqWrite | input | 1 | 1 = write access |
| memRd | output | 1 | Word read strobe, data expected next cycle |
| memWr | output | 1 | Word write strobe |
| memAddr | output | 32 | Byte address of the entry |
| memWdata | output | 32 | Entry write data |
| memRdata | input | 32 | Entry read data |
| rspValid | output | 1 | Response strobe |
| rspFault | output | 1 | Page fault indication |
| rspPhys | output | 32 | Physical address (zero on fault) |

## Verification
The bench uses page tables that deny access at the directory level only, at the table level only, and through a read-only table entry. A walker that took permissions from a single level would allow one of these accesses when it must fault. The bench counts every read and write at the memory port. A cache hit that still touched memory, a fault that wrote back flags, or a flag written when it was already set would each change those counts. A clean cached page is written to check that a walker skipping the dirty update leaves bit 6 clear in memory. The bench also fills 33 pages and then checks which page was evicted, which exposes a replacement pointer that does not wrap or that advances when an existing entry is updated.

// File: rtl/walkerPkg.sv
package walkerPkg;
  localparam int PAGE_W  = 12;
  localparam int FRAME_W = 20;
  localparam int IDX_W   = 10;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_ACCESS  = 5;
  localparam int BIT_DIRTY   = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_RD, ST_DIR_CHK, ST_TBL_RD, ST_TBL_CHK, ST_DIR_WB, ST_TBL_WB
  } walkState_t;

  typedef struct packed {
    logic latchReq;
    logic rspHit;
    logic capDir;
    logic capTbl;
    logic memRd;
    logic memWr;
    logic selTbl;
    logic rspFault;
    logic finish;
  } walkCtl_t;

  typedef struct packed {
    logic hitUse;
    logic hitWalk;
    logic dirPresent;
    logic tblPresent;
    logic walkPermOk;
    logic dirNeedA;
    logic tblNeedUpd;
  } walkStat_t;

  typedef struct packed {
    logic [FRAME_W-1:0] vpn;
    logic [FRAME_W-1:0] ppn;
    logic               user;
    logic               write;
    logic               dirty;
  } cacheEnt_t;

  function automatic logic permOk(input logic isUser, input logic isWrite,
                                  input logic uBit, input logic wBit);
    return !isUser || (uBit && (!isWrite || wBit));
  endfunction
endpackage

// File: rtl/pageWalkerCache.sv
module pageWalkerCache
  import walkerPkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic [FRAME_W-1:0] lookupVpn,
  output logic               hit,
  output logic [SLOT_W-1:0]  hitSlot,
  output cacheEnt_t          hitEnt,
  input  logic               allocEn,
  input  logic               allocReuse,
  input  logic [SLOT_W-1:0]  allocSlot,
  input  cacheEnt_t          allocEnt
);
  logic [ENTRIES-1:0] matchVec;
  cacheEnt_t          entArr [ENTRIES];
  logic [SLOT_W-1:0]  rrQ;
  logic [SLOT_W-1:0]  wrSlot;
  logic               doWrite;

  assign wrSlot  = allocReuse ? allocSlot : rrQ;
  assign doWrite = allocEn && !flush;

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    logic      vldQ;
    cacheEnt_t entQ;
    always_ff @(posedge clk) begin
      if (!rstN)      vldQ <= 1'b0;
      else if (flush) vldQ <= 1'b0;
      else if (doWrite && wrSlot == SLOT_W'(g)) vldQ <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (doWrite && wrSlot == SLOT_W'(g)) entQ <= allocEnt;
    end
    assign matchVec[g] = vldQ && (entQ.vpn == lookupVpn);
    assign entArr[g]   = entQ;
  end

  always_comb begin
    hitSlot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitSlot = SLOT_W'(i);
    end
  end

  assign hit    = |matchVec;
  assign hitEnt = entArr[hitSlot];

  always_ff @(posedge clk) begin
    if (!rstN) rrQ <= '0;
    else if (doWrite && !allocReuse)
      rrQ <= (rrQ == SLOT_W'(ENTRIES - 1)) ? '0 : rrQ + 1'b1;
  end
endmodule

// File: rtl/pageWalkerCtrl.sv
module pageWalkerCtrl
  import walkerPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  walkStat_t stat,
  output logic      reqReady,
  output walkCtl_t  ctl
);
  walkState_t stateQ, stateD;

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (stat.hitUse) ctl.rspHit = 1'b1;
          else begin
            ctl.latchReq = 1'b1;
            stateD       = ST_DIR_RD;
          end
        end
      end
      ST_DIR_RD: begin
        ctl.memRd = 1'b1;
        stateD    = ST_DIR_CHK;
      end
      ST_DIR_CHK: begin
        ctl.capDir = 1'b1;
        if (!stat.dirPresent) begin
          ctl.rspFault = 1'b1;
          stateD       = ST_IDLE;
        end else stateD = ST_TBL_RD;
      end
      ST_TBL_RD: begin
        ctl.memRd  = 1'b1;
        ctl.selTbl = 1'b1;
        stateD     = ST_TBL_CHK;
      end
      ST_TBL_CHK: begin
        ctl.capTbl = 1'b1;
        if (!stat.tblPresent || !stat.walkPermOk) begin
          ctl.rspFault = 1'b1;
          stateD       = ST_IDLE;
        end else if (stat.dirNeedA) stateD = ST_DIR_WB;
        else if (stat.tblNeedUpd)   stateD = ST_TBL_WB;
        else begin
          ctl.finish = 1'b1;
          stateD     = ST_IDLE;
        end
      end
      ST_DIR_WB: begin
        ctl.memWr = 1'b1;
        if (stat.tblNeedUpd) stateD = ST_TBL_WB;
        else begin
          ctl.finish = 1'b1;
          stateD     = ST_IDLE;
        end
      end
      ST_TBL_WB: begin
        ctl.memWr  = 1'b1;
        ctl.selTbl = 1'b1;
        ctl.finish = 1'b1;
        stateD     = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady = (stateQ == ST_IDLE);
endmodule

// File: rtl/pageWalkerDp.sv
module pageWalkerDp
  import walkerPkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  walkCtl_t           ctl,
  input  logic [FRAME_W-1:0] dirFrame,
  input  logic [31:0]        reqAddr,
  input  logic               reqUser,
  input  logic               reqWrite,
  input  logic [31:0]        memRdata,
  input  logic               hit,
  input  logic [SLOT_W-1:0]  hitSlot,
  input  cacheEnt_t          hitEnt,
  output walkStat_t          stat,
  output logic [31:0]        memAddr,
  output logic [31:0]        memWdata,
  output logic               allocEn,
  output logic               allocReuse,
  output logic [SLOT_W-1:0]  allocSlot,
  output cacheEnt_t          allocEnt,
  output logic               rspValid,
  output logic               rspFault,
  output logic [31:0]        rspPhys
);
  logic [31:0]       vaddrQ, dirQ, tblQ;
  logic              userQ, writeQ, staleQ, hitQ;
  logic [SLOT_W-1:0] hitSlotQ;
  logic [31:0]       dirCur, tblCur;
  logic              hitPermOk, effUser, effWrite;

  assign dirCur = ctl.capDir ? memRdata : dirQ;
  assign tblCur = ctl.capTbl ? memRdata : tblQ;

  assign hitPermOk = permOk(reqUser, reqWrite, hitEnt.user, hitEnt.write);
  assign effUser   = dirQ[BIT_USER] & tblCur[BIT_USER];
  assign effWrite  = dirQ[BIT_WRITE] & tblCur[BIT_WRITE];

  always_comb begin
    stat.hitWalk    = hit && hitPermOk && reqWrite && !hitEnt.dirty;
    stat.hitUse     = hit && !stat.hitWalk;
    stat.dirPresent = dirCur[BIT_PRESENT];
    stat.tblPresent = tblCur[BIT_PRESENT];
    stat.walkPermOk = permOk(userQ, writeQ, effUser, effWrite);
    stat.dirNeedA   = !dirQ[BIT_ACCESS];
    stat.tblNeedUpd = !tblCur[BIT_ACCESS] || (writeQ && !tblCur[BIT_DIRTY]);
  end

  always_comb begin
    logic [31:0] setBits;
    setBits = '0;
    setBits[BIT_ACCESS] = 1'b1;
    if (ctl.selTbl) begin
      setBits[BIT_DIRTY] = writeQ;
      memAddr  = {dirQ[31:PAGE_W], vaddrQ[PAGE_W+IDX_W-1:PAGE_W], 2'b00};
      memWdata = tblQ | setBits;
    end else begin
      memAddr  = {dirFrame, vaddrQ[31:PAGE_W+IDX_W], 2'b00};
      memWdata = dirQ | setBits;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.latchReq) begin
      vaddrQ   <= reqAddr;
      userQ    <= reqUser;
      writeQ   <= reqWrite;
      hitQ     <= hit;
      hitSlotQ <= hitSlot;
    end
    if (ctl.capDir) dirQ <= memRdata;
    if (ctl.capTbl) tblQ <= memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             staleQ <= 1'b0;
    else if (ctl.latchReq) staleQ <= 1'b0;
    else if (flush)        staleQ <= 1'b1;
  end

  assign allocEn        = ctl.finish && !staleQ && !flush;
  assign allocReuse     = hitQ;
  assign allocSlot      = hitSlotQ;
  assign allocEnt.vpn   = vaddrQ[31:PAGE_W];
  assign allocEnt.ppn   = tblCur[31:PAGE_W];
  assign allocEnt.user  = effUser;
  assign allocEnt.write = effWrite;
  assign allocEnt.dirty = tblCur[BIT_DIRTY] | writeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspPhys  <= '0;
    end else begin
      rspValid <= ctl.rspHit | ctl.rspFault | ctl.finish;
      rspFault <= ctl.rspFault | (ctl.rspHit & !hitPermOk);
      if (ctl.finish)
        rspPhys <= {tblCur[31:PAGE_W], vaddrQ[PAGE_W-1:0]};
      else if (ctl.rspHit && hitPermOk)
        rspPhys <= {hitEnt.ppn, reqAddr[PAGE_W-1:0]};
      else
        rspPhys <= '0;
    end
  end
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import walkerPkg::*;
#(
  parameter int CACHE_ENTRIES = 32,
  localparam int SLOT_W = (CACHE_ENTRIES > 1) ? $clog2(CACHE_ENTRIES) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic [19:0] dirFrame,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  input  logic        reqUser,
  input  logic        reqWrite,
  output logic        memRd,
  output logic        memWr,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic        rspValid,
  output logic        rspFault,
  output logic [31:0] rspPhys
);
  walkCtl_t          ctl;
  walkStat_t         stat;
  logic              hit, allocEn, allocReuse;
  logic [SLOT_W-1:0] hitSlot, allocSlot;
  cacheEnt_t         hitEnt, allocEnt;

  pageWalkerCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .stat(stat),
    .reqReady(reqReady), .ctl(ctl)
  );

  pageWalkerDp #(.SLOT_W(SLOT_W)) u_dp (
    .clk(clk), .rstN(rstN), .flush(flush), .ctl(ctl), .dirFrame(dirFrame),
    .reqAddr(reqAddr), .reqUser(reqUser), .reqWrite(reqWrite),
    .memRdata(memRdata), .hit(hit), .hitSlot(hitSlot), .hitEnt(hitEnt),
    .stat(stat), .memAddr(memAddr), .memWdata(memWdata),
    .allocEn(allocEn), .allocReuse(allocReuse), .allocSlot(allocSlot),
    .allocEnt(allocEnt), .rspValid(rspValid), .rspFault(rspFault),
    .rspPhys(rspPhys)
  );

  pageWalkerCache #(.ENTRIES(CACHE_ENTRIES)) u_cache (
    .clk(clk), .rstN(rstN), .flush(flush), .lookupVpn(reqAddr[31:12]),
    .hit(hit), .hitSlot(hitSlot), .hitEnt(hitEnt), .allocEn(allocEn),
    .allocReuse(allocReuse), .allocSlot(allocSlot), .allocEnt(allocEnt)
  );

  assign memRd = ctl.memRd;
  assign memWr = ctl.memWr;
endmodule

// File: rtl/pageWalkerChk.sv
module pageWalkerChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        memRd,
  input logic        memWr,
  input logic [31:0] memWdata,
  input logic        rspValid,
  input logic        rspFault,
  input logic [31:0] rspPhys
);
  p_mem_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  p_fault_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspPhys == 32'h0));

  p_wb_access_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> memWdata[5]);

  p_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (rspValid || !reqReady));

  p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memRd && !memWr));
endmodule

bind pageWalker pageWalkerChk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
  .rspValid(rspValid), .rspFault(rspFault), .rspPhys(rspPhys)
);

// File: tb/pageWalker_tb.sv
module pageWalker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic [19:0] dirFrame = 20'h0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqUser = 1'b0;
  logic        reqWrite = 1'b0;
  logic        memRd, memWr;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        rspValid, rspFault;
  logic [31:0] rspPhys;

  int errors = 0;
  int checks = 0;
  int rdCnt = 0;
  int wrCnt = 0;
  logic [31:0] rdAddr0, rdAddr1;
  logic [31:0] mem [4096];

  always #4 clk = ~clk;

  pageWalker u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .dirFrame(dirFrame),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqUser(reqUser), .reqWrite(reqWrite), .memRd(memRd), .memWr(memWr),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .rspValid(rspValid), .rspFault(rspFault), .rspPhys(rspPhys)
  );

  always @(posedge clk) begin
    if (memRd) begin
      memRdata <= mem[memAddr[13:2]];
      if (rdCnt == 0) rdAddr0 <= memAddr;
      if (rdCnt == 1) rdAddr1 <= memAddr;
      rdCnt <= rdCnt + 1;
    end
    if (memWr) begin
      mem[memAddr[13:2]] <= memWdata;
      wrCnt <= wrCnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic        gotFault;
  logic [31:0] gotPhys;
  int          gotCycles;

  task automatic doReq(input logic [31:0] addr, input logic usr, input logic wr);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqAddr = addr; reqUser = usr; reqWrite = wr; reqValid = 1'b1;
    rdCnt = 0; wrCnt = 0;
    @(negedge clk);
    reqValid = 1'b0;
    gotCycles = 1;
    while (!rspValid && gotCycles < 100) begin
      @(negedge clk);
      gotCycles++;
    end
    gotFault = rspFault;
    gotPhys  = rspPhys;
  endtask

  // {addr, user, write, expFault, expPhys}
  localparam logic [66:0] VECS [9] = '{
    {32'h0000_0123, 1'b1, 1'b0, 1'b0, 32'hAAAA_A123},
    {32'h0000_1456, 1'b1, 1'b0, 1'b1, 32'h0},
    {32'h0000_1456, 1'b0, 1'b1, 1'b0, 32'hBBBB_B456},
    {32'h0000_2000, 1'b0, 1'b0, 1'b1, 32'h0},
    {32'h0000_3010, 1'b1, 1'b1, 1'b1, 32'h0},
    {32'h0000_3010, 1'b1, 1'b0, 1'b0, 32'hCCCC_C010},
    {32'h0040_0ABC, 1'b1, 1'b1, 1'b1, 32'h0},
    {32'h0040_0ABC, 1'b0, 1'b1, 1'b0, 32'hDDDD_DABC},
    {32'h0080_0000, 1'b0, 1'b0, 1'b1, 32'h0}
  };

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[0] = 32'h0000_1007;
    mem[1] = 32'h0000_2005;
    mem[3] = 32'h0000_3007;
    mem[12'h400] = 32'hAAAA_A007;
    mem[12'h401] = 32'hBBBB_B003;
    mem[12'h403] = 32'hCCCC_C005;
    mem[12'h800] = 32'hDDDD_D007;
    for (int i = 0; i < 64; i++) mem[12'hC00 + i] = ((32'h100 + i) << 12) | 32'h7;

    repeat (3) @(negedge clk);
    check("R11 reset reqReady", {31'h0, reqReady}, 32'h1);
    check("R11 reset rspValid", {31'h0, rspValid}, 32'h0);
    check("R11 reset mem strobes", {30'h0, memRd, memWr}, 32'h0);
    rstN = 1'b1;

    // R1 R3 R4: vector table
    for (int v = 0; v < 9; v++) begin
      doReq(VECS[v][66:35], VECS[v][34], VECS[v][33]);
      check($sformatf("R4 vec%0d fault", v), {31'h0, gotFault}, {31'h0, VECS[v][32]});
      check($sformatf("R1 vec%0d phys", v), gotPhys, VECS[v][31:0]);
      if (VECS[v][32]) check($sformatf("R3 vec%0d no writeback", v), wrCnt, 0);
    end

    // R5 R6: flags in memory
    check("R5 dir entry accessed", mem[0], 32'h0000_1027);
    check("R5 read leaves dirty clear", mem[12'h400], 32'hAAAA_A027);
    check("R6 write sets dirty", mem[12'h401], 32'hBBBB_B063);
    check("R5 read-only entry accessed", mem[12'h403], 32'hCCCC_C025);
    check("R3 absent entry untouched", mem[12'h402], 32'h0);
    check("R3 absent dir untouched", mem[2], 32'h0);

    // R7: hit
    doReq(32'h0000_0123, 1'b1, 1'b0);
    check("R7 hit latency", gotCycles, 1);
    check("R7 hit no memory", rdCnt + wrCnt, 0);
    check("R7 hit phys", gotPhys, 32'hAAAA_A123);
    // R4: cached supervisor-only page denies user
    doReq(32'h0000_1456, 1'b1, 1'b0);
    check("R4 cached deny fault", {31'h0, gotFault}, 32'h1);
    check("R4 cached deny no memory", rdCnt, 0);

    // R8: write to clean cached page
    doReq(32'h0000_0123, 1'b1, 1'b1);
    check("R8 clean write walks", rdCnt, 2);
    check("R8 dirty written", mem[12'h400], 32'hAAAA_A067);
    check("R8 phys", gotPhys, 32'hAAAA_A123);
    doReq(32'h0000_0123, 1'b1, 1'b1);
    check("R8 second write hits", rdCnt, 0);

    // R10: fault not cached, flush
    doReq(32'h0000_2000, 1'b0, 1'b0);
    check("R10 fault rewalks", rdCnt, 2);
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    doReq(32'h0000_0123, 1'b1, 1'b0);
    check("R10 flush forces walk", rdCnt, 2);

    // R9 R2: fill 33 pages
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 33; i++) begin
      doReq(32'h00C0_0000 | (i << 12), 1'b1, 1'b0);
      if (i == 0) begin
        check("R2 dir read addr", rdAddr0, 32'h0000_000C);
        check("R2 table read addr", rdAddr1, 32'h0000_3000);
      end
      if (i == 32) check("R9 page32 phys", gotPhys, 32'h0012_0000);
    end
    doReq(32'h00C0_1000, 1'b1, 1'b0);
    check("R9 second page still hit", rdCnt, 0);
    doReq(32'h00C0_0000, 1'b1, 1'b0);
    check("R9 first page evicted", rdCnt, 2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule